// File: doc/BRIEF.md
# Virtual-Channel Cell Scheduler

This block sits between up to sixteen per-channel word streams and a framing encoder that drives a single serial link. Each channel offers 64-bit words with a valid/ready handshake, an end-of-frame flag, an 8-bit byte-enable mask and an 8-bit user tag. The scheduler grants the link to one channel at a time and cuts every frame into cells of at most `CELL_WORDS` words. Before each cell it emits a start marker and after each cell an end marker. The encoder turns these markers into control words.

The choice of channel is made again at every cell boundary. It is round-robin over the channels that have data waiting and whose remote receive buffer is not paused. A frame longer than one cell may therefore be interleaved with cells of other channels. When `INTERLEAVE` is 0 the channel that holds an unfinished frame keeps the link until its last word, and cell markers are still inserted. A 12-bit packet number is kept for every channel. The byte count and the user tag of a frame's last word travel in its final end marker.

Top module: `vc_cell_sched`

## Requirements
- R1: While reset is held and in the cycle after it is released, `o_kind` is 0 (no item) and every `s_tready` bit is 0.
- R2: A channel is eligible when `s_tvalid` is high and `rem_pause` is low. Among the eligible channels, the grant goes to the first one in ascending index order after the channel that was granted last, wrapping around. After reset the search starts at channel 0.
- R3: A channel whose `rem_pause` bit is high when a cell would start is not granted. A pause raised while a cell is in progress does not stop that cell. It only blocks the channel's next cell start.
- R4: A cell carries at most `CELL_WORDS` data words. A cell that ends without the frame's last word carries exactly `CELL_WORDS` words.
- R5: With `INTERLEAVE`=1, the cell that follows a cell of channel X is taken from another eligible channel whenever one exists.
- R6: With `INTERLEAVE`=0, a channel with an unfinished frame keeps the link for all of its cells until its last word. No other channel starts a cell in that time.
- R7: `o_kind` encodes the item: 1 = start marker, 2 = data word, 3 = end marker. A start marker drives `o_first`=1 for the first cell of a frame and 0 for later cells. `o_vc` holds the channel number from the start marker through the end marker.
- R8: Each channel has its own 12-bit packet number, starting at 0 after reset. A start marker shows the current value on `o_pkt`, and the value then increments by one per cell, wrapping from 4095 to 0.
- R9: An end marker drives `o_final`=1 when the cell holds the frame's last word. In that case `o_bytes` is the number of set bits of that word's `tkeep` (0 to 8) and `o_tag` is its `tuser`. Otherwise `o_final`=0, `o_bytes`=8 and `o_tag`=0.
- R10: Words leave in their arrival order and unchanged. The start marker appears one cycle after the arbitration edge. A data word appears one cycle after its handshake edge. The end marker appears one cycle after the cell's last data word.
- R11: At most one `s_tready` bit is high at any time. It is high only for the granted channel and only between the cell's start marker and its last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tvalid | input | NUM_CH | Per-channel word valid |
| s_tready | output | NUM_CH | Per-channel word accept |
| s_tdata | input | NUM_CH*64 | Per-channel data, channel c at bits c*64 upward |
| s_tlast | input | NUM_CH | Per-channel last word of frame |
| s_tkeep | input | NUM_CH*8 | Per-channel byte enables of the last word |
| s_tuser | input | NUM_CH*8 | Per-channel user tag of the last word |
| rem_pause | input | NUM_CH | Remote buffer of the channel has under one cell of room |
| o_kind | output | 2 | Item type: 0 none, 1 start, 2 data, 3 end |
| o_data | output | 64 | Data word when o_kind is 2 |
| o_first | output | 1 | Start marker opens a frame |
| o_final | output | 1 | End marker closes a frame |
| o_vc | output | 4 | Channel of the current cell |
| o_pkt | output | 12 | Packet number of the cell |
| o_bytes | output | 4 | Valid byte count of the final word |
| o_tag | output | 8 | User tag of the final word |

## Verification
The start marker is due one cycle after the edge at which a request is eligible. A data word is due one cycle after the edge at which the ready and valid of the word were both high, and the end marker one cycle after the cell's last word. The bench drives inputs and samples outputs on the falling edge, so each item is checked exactly one sample after the edge that created it. The timing checks after a single request count these edges directly. The scoreboard pops one expected word per observed data item, and it checks each marker against per-channel models of the frame-open flag and the packet number.

// File: rtl/vc_cell_sched.sv
module vc_cell_sched #(
  parameter int NUM_CH     = 16,
  parameter int CELL_WORDS = 128,
  parameter bit INTERLEAVE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CH-1:0]    s_tvalid,
  output logic [NUM_CH-1:0]    s_tready,
  input  logic [NUM_CH*64-1:0] s_tdata,
  input  logic [NUM_CH-1:0]    s_tlast,
  input  logic [NUM_CH*8-1:0]  s_tkeep,
  input  logic [NUM_CH*8-1:0]  s_tuser,
  input  logic [NUM_CH-1:0]    rem_pause,
  output logic [1:0]           o_kind,
  output logic [63:0]          o_data,
  output logic                 o_first,
  output logic                 o_final,
  output logic [3:0]           o_vc,
  output logic [11:0]          o_pkt,
  output logic [3:0]           o_bytes,
  output logic [7:0]           o_tag
);
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int CW  = $clog2(CELL_WORDS + 1);
  localparam logic [1:0] K_NONE = 2'd0, K_START = 2'd1, K_DATA = 2'd2, K_END = 2'd3;

  typedef enum logic [1:0] {S_ARB, S_DATA, S_END} st_t;

  st_t              st;
  logic [CHW-1:0]   cur, last, win;
  logic [CW-1:0]    cnt;
  logic [NUM_CH-1:0] open, mask, req, pause_q;
  logic [11:0]      pkt [NUM_CH];
  logic             found;

  wire [63:0] dat_c  = s_tdata[cur*64 +: 64];
  wire [7:0]  keep_c = s_tkeep[cur*8 +: 8];
  wire [7:0]  user_c = s_tuser[cur*8 +: 8];
  wire        hs     = (st == S_DATA) && s_tvalid[cur];

  always_comb begin
    mask = '1;
    if (!INTERLEAVE && open[cur]) begin
      mask = '0;
      mask[cur] = 1'b1;
    end
    req = s_tvalid & ~rem_pause & mask;
  end

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = 1; i <= NUM_CH; i++) begin
      int idx;
      idx = (int'(last) + i) % NUM_CH;
      if (!found && req[idx]) begin
        found = 1'b1;
        win   = CHW'(idx);
      end
    end
  end

  always_comb begin
    s_tready = '0;
    if (st == S_DATA) s_tready[cur] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_ARB;
      cur     <= '0;
      last    <= CHW'(NUM_CH - 1);
      cnt     <= '0;
      open    <= '0;
      pause_q <= '0;
      o_kind  <= K_NONE;
      o_data  <= '0;
      o_first <= 1'b0;
      o_final <= 1'b0;
      o_vc    <= '0;
      o_pkt   <= '0;
      o_bytes <= '0;
      o_tag   <= '0;
      for (int c = 0; c < NUM_CH; c++) pkt[c] <= '0;
    end else begin
      pause_q <= rem_pause;
      o_kind  <= K_NONE;
      case (st)
        S_ARB: if (found) begin
          cur       <= win;
          last      <= win;
          o_kind    <= K_START;
          o_first   <= !open[win];
          o_pkt     <= pkt[win];
          o_vc      <= 4'(win);
          pkt[win]  <= pkt[win] + 12'd1;
          open[win] <= 1'b1;
          cnt       <= '0;
          st        <= S_DATA;
        end
        S_DATA: if (hs) begin
          o_kind <= K_DATA;
          o_data <= dat_c;
          cnt    <= cnt + CW'(1);
          if (s_tlast[cur]) begin
            o_final   <= 1'b1;
            o_bytes   <= 4'($countones(keep_c));
            o_tag     <= user_c;
            open[cur] <= 1'b0;
            st        <= S_END;
          end else if (cnt == CW'(CELL_WORDS - 1)) begin
            o_final <= 1'b0;
            o_bytes <= 4'd8;
            o_tag   <= '0;
            st      <= S_END;
          end
        end
        default: begin
          o_kind <= K_END;
          st     <= S_ARB;
        end
      endcase
    end
  end

  AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(s_tready)); // R11
  AST_READY_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tready != '0) |-> s_tready[o_vc[CHW-1:0]]); // R11
  AST_PAUSE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (o_kind == K_START) |-> !pause_q[o_vc[CHW-1:0]]); // R3
  AST_END_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (o_kind == K_END) |-> ($past(o_kind) == K_DATA)); // R10
  AST_START_NOT_REPEATED: assert property (@(posedge clk) disable iff (!rst_n)
    (o_kind == K_START) |=> (o_kind != K_START) && (o_kind != K_END)); // R7
  AST_CELL_END_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (o_kind == K_END && !o_final) |-> (o_bytes == 4'd8 && o_tag == 8'd0)); // R9
  AST_BYTES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (o_kind == K_END) |-> (o_bytes <= 4'd8)); // R9
endmodule

// File: tb/test_vc_cell_sched.sv
module test_vc_cell_sched;
  localparam int NC = 4;
  localparam int CELL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0;
  always #5 clk = ~clk;

  logic        tv_a [NC];
  logic [63:0] td_a [NC];
  logic        tl_a [NC];
  logic [7:0]  tk_a [NC];
  logic [7:0]  tu_a [NC];
  logic [NC-1:0] tv, tl, pause, tr, tr_il, tr_lk;
  logic [NC*64-1:0] td;
  logic [NC*8-1:0]  tk, tu;

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      tv[c] = tv_a[c]; tl[c] = tl_a[c];
      td[c*64 +: 64] = td_a[c]; tk[c*8 +: 8] = tk_a[c]; tu[c*8 +: 8] = tu_a[c];
    end
  end

  logic [1:0] k_il, k_lk, m_kind;
  logic [63:0] d_il, d_lk, m_data;
  logic f_il, f_lk, m_first, e_il, e_lk, m_final;
  logic [3:0] v_il, v_lk, m_vc, b_il, b_lk, m_bytes;
  logic [11:0] p_il, p_lk, m_pkt;
  logic [7:0] g_il, g_lk, m_tag;

  vc_cell_sched #(.NUM_CH(NC), .CELL_WORDS(CELL), .INTERLEAVE(1'b1)) i_vc_cell_sched (
    .clk(clk), .rst_n(rst_n), .s_tvalid(sel ? '0 : tv), .s_tready(tr_il), .s_tdata(td),
    .s_tlast(tl), .s_tkeep(tk), .s_tuser(tu), .rem_pause(pause), .o_kind(k_il), .o_data(d_il),
    .o_first(f_il), .o_final(e_il), .o_vc(v_il), .o_pkt(p_il), .o_bytes(b_il), .o_tag(g_il));

  vc_cell_sched #(.NUM_CH(NC), .CELL_WORDS(CELL), .INTERLEAVE(1'b0)) i_vc_cell_sched_lock (
    .clk(clk), .rst_n(rst_n), .s_tvalid(sel ? tv : '0), .s_tready(tr_lk), .s_tdata(td),
    .s_tlast(tl), .s_tkeep(tk), .s_tuser(tu), .rem_pause(pause), .o_kind(k_lk), .o_data(d_lk),
    .o_first(f_lk), .o_final(e_lk), .o_vc(v_lk), .o_pkt(p_lk), .o_bytes(b_lk), .o_tag(g_lk));

  assign tr      = sel ? tr_lk : tr_il;
  assign m_kind  = sel ? k_lk : k_il;
  assign m_data  = sel ? d_lk : d_il;
  assign m_first = sel ? f_lk : f_il;
  assign m_final = sel ? e_lk : e_il;
  assign m_vc    = sel ? v_lk : v_il;
  assign m_pkt   = sel ? p_lk : p_il;
  assign m_bytes = sel ? b_lk : b_il;
  assign m_tag   = sel ? g_lk : g_il;

  int n_chk = 0, n_fail = 0, frame_id = 0, words = 0, dcount = 0, mcur = 0;
  logic [76:0] expq [NC][$];
  int slog [$];
  logic [11:0] exp_pkt [NC];
  logic open_m [NC];
  int seen [NC];
  bit wrap_seen = 0, lastflag = 0;
  logic [3:0] lb;
  logic [7:0] lt;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic clear_model();
    for (int c = 0; c < NC; c++) begin
      expq[c].delete(); exp_pkt[c] = '0; open_m[c] = 1'b0; seen[c] = 0;
      tv_a[c] = 0; td_a[c] = '0; tl_a[c] = 0; tk_a[c] = '0; tu_a[c] = '0;
    end
    slog.delete();
    pause = '0;
  endtask

  task automatic send_frame(input int ch, input int n, input int kb, input logic [7:0] tag);
    int fid;
    fid = frame_id++;
    for (int w = 0; w < n; w++) begin
      logic last;
      logic [63:0] d;
      last = (w == n - 1);
      d = {8'(ch), 24'(fid), 32'(w)};
      expq[ch].push_back({last, last ? 4'(kb) : 4'd8, last ? tag : 8'd0, d});
      tv_a[ch] = 1'b1; td_a[ch] = d; tl_a[ch] = last;
      tk_a[ch] = last ? 8'((16'd1 << kb) - 16'd1) : 8'hFF;
      tu_a[ch] = tag;
      while (!tr[ch]) @(negedge clk);
      @(negedge clk);
    end
    tv_a[ch] = 1'b0; tl_a[ch] = 1'b0;
  endtask

  task automatic wait_done();
    int guard;
    guard = 0;
    while ((expq[0].size() + expq[1].size() + expq[2].size() + expq[3].size()) != 0 && guard < 20000) begin
      @(negedge clk); guard++;
    end
    repeat (6) @(negedge clk);
  endtask

  always @(negedge clk) if (rst_n) begin
    case (m_kind)
      2'd1: begin
        chk(m_first == !open_m[m_vc], "R7 first flag", 64'(m_first), 64'(!open_m[m_vc]));
        chk(m_pkt == exp_pkt[m_vc], "R8 packet number", 64'(m_pkt), 64'(exp_pkt[m_vc]));
        if (m_pkt == 12'd0 && seen[m_vc] > 0) wrap_seen = 1;
        seen[m_vc]++;
        exp_pkt[m_vc] = exp_pkt[m_vc] + 12'd1;
        slog.push_back(int'(m_vc));
        mcur = int'(m_vc); words = 0;
      end
      2'd2: begin
        words++; dcount++;
        chk(words <= CELL, "R4 cell length", 64'(words), 64'(CELL));
        if (expq[mcur].size() == 0) chk(1'b0, "R10 unexpected word", m_data, 64'd0);
        else begin
          logic [76:0] it;
          it = expq[mcur].pop_front();
          chk(m_data == it[63:0], "R10 data order", m_data, it[63:0]);
          lastflag = it[76]; lb = it[75:72]; lt = it[71:64];
        end
      end
      2'd3: begin
        chk(m_final == lastflag, "R9 final flag", 64'(m_final), 64'(lastflag));
        chk(m_bytes == lb, "R9 byte count", 64'(m_bytes), 64'(lb));
        chk(m_tag == lt, "R9 user tag", 64'(m_tag), 64'(lt));
        if (!lastflag) chk(words == CELL, "R4 full cell", 64'(words), 64'(CELL));
        open_m[mcur] = !lastflag;
      end
      default: ;
    endcase
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    report();
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    chk(m_kind == 2'd0, "R1 kind in reset", 64'(m_kind), 64'd0);
    chk(tr == '0, "R1 ready in reset", 64'(tr), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(m_kind == 2'd0 && tr == '0, "R1 after release", 64'({m_kind, tr}), 64'd0);

    // R10 timing of a lone frame on channel 0
    fork send_frame(0, 3, 4, 8'hA5); join_none
    @(negedge clk);
    chk(m_kind == 2'd1 && m_vc == 4'd0, "R10 start one cycle after request", 64'({m_kind, m_vc}), 64'h10);
    chk(tr == 4'b0001, "R11 ready on owner", 64'(tr), 64'h1);
    @(negedge clk);
    chk(m_kind == 2'd2 && m_data == {8'd0, 24'd0, 32'd0}, "R10 first word", m_data, 64'd0);
    wait_done();
    chk(slog.size() == 1, "R2 single grant", 64'(slog.size()), 64'd1);

    // R5 R2 interleave of two long frames; last grant was 0, so 1 goes first
    slog.delete();
    fork send_frame(0, 8, 8, 8'h11); send_frame(1, 8, 0, 8'h22); join
    wait_done();
    chk(slog.size() == 4, "R5 cell count", 64'(slog.size()), 64'd4);
    if (slog.size() == 4)
      chk(slog[0] == 1 && slog[1] == 0 && slog[2] == 1 && slog[3] == 0, "R5 R2 alternation",
          64'({slog[0][3:0], slog[1][3:0], slog[2][3:0], slog[3][3:0]}), 64'h1010);

    // R3 paused channel never starts
    slog.delete();
    pause[2] = 1'b1;
    fork send_frame(2, 2, 5, 8'h33); join_none
    repeat (20) @(negedge clk);
    chk(slog.size() == 0 && m_kind == 2'd0, "R3 paused channel idle", 64'(slog.size()), 64'd0);
    pause[2] = 1'b0;
    wait_done();
    chk(slog.size() == 1 && slog[0] == 2, "R3 start after release", 64'(slog.size()), 64'd1);

    // R3 pause raised mid-cell
    slog.delete(); dcount = 0;
    fork send_frame(1, 8, 3, 8'h44); join_none
    while (m_kind != 2'd2) @(negedge clk);
    pause[1] = 1'b1;
    repeat (30) @(negedge clk);
    chk(dcount == CELL, "R3 running cell completes", 64'(dcount), 64'(CELL));
    chk(slog.size() == 1, "R3 next cell blocked", 64'(slog.size()), 64'd1);
    pause[1] = 1'b0;
    wait_done();
    chk(slog.size() == 2 && dcount == 8, "R3 frame resumes", 64'(dcount), 64'd8);

    // R8 packet number wrap on channel 3
    wrap_seen = 0;
    for (int f = 0; f < 4097; f++) send_frame(3, 1, 8, 8'h55);
    wait_done();
    chk(wrap_seen, "R8 wrap to zero", 64'(wrap_seen), 64'd1);
    chk(exp_pkt[3] == 12'd1, "R8 count after wrap", 64'(exp_pkt[3]), 64'd1);

    // R6 lock mode
    rst_n = 1'b0;
    clear_model();
    sel = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork send_frame(0, 8, 2, 8'h66); send_frame(1, 8, 7, 8'h77); join
    wait_done();
    chk(slog.size() == 4, "R6 cell count", 64'(slog.size()), 64'd4);
    if (slog.size() == 4)
      chk(slog[0] == 0 && slog[1] == 0 && slog[2] == 1 && slog[3] == 1, "R6 channel keeps link",
          64'({slog[0][3:0], slog[1][3:0], slog[2][3:0], slog[3][3:0]}), 64'h0011);
    report();
  end
endmodule